// File: doc/BRIEF.md
# Static LCD Backplane and Segment Phase Generator

This block produces the logic-level drive for a static liquid-crystal display. An 8-bit divider runs on an oscillator enable pulse and makes a square-wave backplane with a 50% duty cycle. The backplane runs at one 256th of the tick rate. Each segment output follows the backplane. When a segment is dark it is in phase with the backplane. When a segment is lit it is inverted against the backplane. No DC voltage is left across any segment over a full backplane period.

A two-bit test selector sets the display mode. The modes are: show the latched pattern, force every segment dark, force every segment lit, or light alternate segments. This supports open and short testing of the glass. A supply-good flag blanks the display when it is low. The backplane and every segment are driven to the same low level, the divider is cleared, and the waveform restarts cleanly from phase zero when the supply returns. Outputs are registered together, so the backplane and the segments change on the same clock edge.

Top module: `lcd_phase_drv`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), `bp_out` and every bit of `seg_out` are 0 after that edge, and the divider count is cleared.
- R2: The divider advances by one only on edges where `osc_tick` is 1. `bp_out` equals bit 7 of the count (count/128 mod 2), so it toggles every 128 ticks, with a period of 256 ticks.
- R3: With `test_sel` = 2'b00, `seg_out[i]` = `bp_out` XOR `pattern[i]`. A 1 lights the segment by putting it out of phase with the backplane.
- R4: With `test_sel` = 2'b01, every segment is dark: `seg_out[i]` = `bp_out`.
- R5: With `test_sel` = 2'b10, every segment is lit: `seg_out[i]` = NOT `bp_out`.
- R6: With `test_sel` = 2'b11, the odd-numbered segments (bit indices 0, 2, 4, ...) are lit and the even-numbered segments (bit indices 1, 3, ...) are dark.
- R7: An edge that samples `supply_ok` = 0 drives `bp_out` and all of `seg_out` to 0 and clears the divider. After the supply returns, the count restarts from zero.
- R8: The outputs are registered. The values sampled at an edge appear after that edge, and the backplane and the segments switch on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick | input | 1 | Oscillator enable pulse, one clock wide |
| pattern | input | 38 | Latched segment pattern, 1 = lit |
| test_sel | input | 2 | Display mode: {T2, T1} |
| supply_ok | input | 1 | Logic supply good; low blanks the display |
| bp_out | output | 1 | Backplane drive level |
| seg_out | output | 38 | Segment drive levels |

## Verification
The bench sweeps all four display modes against several patterns. Ticks arrive on every clock and then on every third clock, and the pattern is changed in the middle of a backplane period. A divider that counts without a tick, or that taps the wrong bit, would put the backplane edges at the wrong times. A swapped mode decode, or an inverted on/off sense, shows up as segments in the wrong phase. An alternating mask shifted by one would light the even-numbered segments instead of the odd ones. The supply is dropped in the middle of a period. A blanking path that left the divider running, or held only the backplane low, would leave a DC voltage across the segments or restart at the wrong phase.

// File: rtl/lcd_drv_pkg.sv
// Shared types for the static LCD phase generator.
package lcd_drv_pkg;
    // Display mode, encoded as {T2, T1}
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_ALL_OFF = 2'b01,
        MODE_ALL_ON  = 2'b10,
        MODE_ALT     = 2'b11
    } disp_mode_e;
endpackage

// File: rtl/lcd_bp_divider.sv
// Backplane divider: free-running count advanced by an oscillator enable.
// Assumes tick is a single-cycle pulse synchronous to clk. The count is
// cleared by reset or when run is low. The phase is the count's MSB.
module lcd_bp_divider #(
    parameter int DIV_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic phase
);
    localparam int MSB = DIV_BITS - 1;

    logic [MSB:0] count_q;

    // Advance the count on each tick; clear on reset or blanking
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign phase = count_q[MSB];
endmodule

// File: rtl/lcd_seg_select.sv
// Segment selector: chooses, per segment, whether it is lit, based on mode.
// Purely combinational. Bit index i is segment number i+1.
module lcd_seg_select
    import lcd_drv_pkg::*;
#(
    parameter int NUM_SEG = 38
) (
    input  disp_mode_e         mode,
    input  logic [NUM_SEG-1:0] pattern,
    output logic [NUM_SEG-1:0] lit
);
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        // Odd-numbered segment (even bit index) is lit in alternating mode
        localparam logic ALT_LIT = ((g % 2) == 0);

        // Decode the lit state of one segment
        always_comb begin
            unique case (mode)
                MODE_NORMAL:  lit[g] = pattern[g];
                MODE_ALL_OFF: lit[g] = 1'b0;
                MODE_ALL_ON:  lit[g] = 1'b1;
                default:      lit[g] = ALT_LIT;
            endcase
        end
    end
endmodule

// File: rtl/lcd_phase_out.sv
// Output stage: registers the backplane and all segment levels together.
// A lit segment is the inverse of the backplane. Blanking forces all levels low.
module lcd_phase_out #(
    parameter int NUM_SEG = 38
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blank,
    input  logic               phase,
    input  logic [NUM_SEG-1:0] lit,
    output logic               bp_q,
    output logic [NUM_SEG-1:0] seg_q
);
    // Register every drive level on the same edge so they never skew
    always_ff @(posedge clk) begin
        if (!rst_n || blank) begin
            bp_q  <= 1'b0;
            seg_q <= '0;
        end else begin
            bp_q  <= phase;
            seg_q <= {NUM_SEG{phase}} ^ lit;
        end
    end
endmodule

// File: rtl/lcd_phase_drv.sv
// Top: static LCD backplane and segment phase generator.
// Assumes osc_tick is synchronous to clk, and pattern is held stable by an
// upstream latch. Outputs are logic levels for the high-voltage translators.
module lcd_phase_drv
    import lcd_drv_pkg::*;
#(
    parameter int NUM_SEG  = 38,
    parameter int DIV_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_tick,
    input  logic [NUM_SEG-1:0] pattern,
    input  logic [1:0]         test_sel,
    input  logic               supply_ok,
    output logic               bp_out,
    output logic [NUM_SEG-1:0] seg_out
);
    logic               phase;
    logic [NUM_SEG-1:0] lit;
    disp_mode_e         mode;

    assign mode = disp_mode_e'(test_sel);

    lcd_bp_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (supply_ok),
        .tick  (osc_tick),
        .phase (phase)
    );

    lcd_seg_select #(.NUM_SEG(NUM_SEG)) u_sel (
        .mode    (mode),
        .pattern (pattern),
        .lit     (lit)
    );

    lcd_phase_out #(.NUM_SEG(NUM_SEG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .blank (!supply_ok),
        .phase (phase),
        .lit   (lit),
        .bp_q  (bp_out),
        .seg_q (seg_out)
    );
endmodule

// File: rtl/lcd_phase_drv_chk.sv
// Checker for lcd_phase_drv: relates mode, pattern, supply and outputs.
module lcd_phase_drv_chk #(
    parameter int NUM_SEG = 38
) (
    input logic               clk,
    input logic               rst_n,
    input logic               osc_tick,
    input logic [NUM_SEG-1:0] pattern,
    input logic [1:0]         test_sel,
    input logic               supply_ok,
    input logic               bp_out,
    input logic [NUM_SEG-1:0] seg_out
);
    function automatic logic [NUM_SEG-1:0] odd_seg_mask();
        logic [NUM_SEG-1:0] m;
        for (int i = 0; i < NUM_SEG; i++) m[i] = ((i % 2) == 0);
        return m;
    endfunction

    // R1: reset clears all drive levels
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (bp_out == 1'b0 && seg_out == '0));

    // R2: no tick, no backplane change
    a_r2_bp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !osc_tick) ##1 supply_ok |=> $stable(bp_out));

    // R3: normal mode follows the pattern
    a_r3_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && test_sel == 2'b00) |=>
            ((seg_out ^ {NUM_SEG{bp_out}}) == $past(pattern)));

    // R4: all off in phase
    a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && test_sel == 2'b01) |=> (seg_out == {NUM_SEG{bp_out}}));

    // R5: all on out of phase
    a_r5_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && test_sel == 2'b10) |=> (seg_out == ~{NUM_SEG{bp_out}}));

    // R6: alternating mode lights odd-numbered segments
    a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && test_sel == 2'b11) |=>
            ((seg_out ^ {NUM_SEG{bp_out}}) == odd_seg_mask()));

    // R7: supply loss blanks everything to one level
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (bp_out == 1'b0 && seg_out == '0));

    // R7: restart after blanking begins at phase zero
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok ##1 supply_ok |=> (bp_out == 1'b0));
endmodule

bind lcd_phase_drv lcd_phase_drv_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .pattern   (pattern),
    .test_sel  (test_sel),
    .supply_ok (supply_ok),
    .bp_out    (bp_out),
    .seg_out   (seg_out)
);

// File: tb/lcd_phase_drv_test.sv
// Bench for lcd_phase_drv: mode and pattern sweeps against an arithmetic model.
module lcd_phase_drv_test;
    localparam int N = 38;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         osc_tick = 1'b0;
    logic [N-1:0] pattern = '0;
    logic [1:0]   test_sel = 2'b00;
    logic         supply_ok = 1'b1;
    wire          bp_out;
    wire  [N-1:0] seg_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state: ticks counted since the last clear
    int           m_ticks = 0;
    logic         exp_bp = 1'b0;
    logic [N-1:0] exp_seg = '0;
    string        exp_tag = "R1";

    always #2 clk = ~clk;

    lcd_phase_drv uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pattern(pattern),
        .test_sel(test_sel), .supply_ok(supply_ok),
        .bp_out(bp_out), .seg_out(seg_out)
    );

    // Model: expected outputs after each edge, from the inputs sampled there
    always @(posedge clk) begin
        logic         ph;
        logic [N-1:0] lit;
        if (!rst_n) begin
            m_ticks = 0; exp_bp = 1'b0; exp_seg = '0; exp_tag = "R1";
        end else if (!supply_ok) begin
            m_ticks = 0; exp_bp = 1'b0; exp_seg = '0; exp_tag = "R7";
        end else begin
            ph = ((m_ticks / 128) % 2) == 1;
            case (test_sel)
                2'b00: begin lit = pattern; exp_tag = "R3"; end
                2'b01: begin lit = '0;      exp_tag = "R4"; end
                2'b10: begin lit = '1;      exp_tag = "R5"; end
                default: begin
                    for (int i = 0; i < N; i++) lit[i] = ((i % 2) == 0);
                    exp_tag = "R6";
                end
            endcase
            exp_bp  = ph;
            exp_seg = {N{ph}} ^ lit;
            if (osc_tick) m_ticks = (m_ticks + 1) % 256;
        end
    end

    task automatic check_outputs();
        total++;
        if (bp_out !== exp_bp) begin
            bad++;
            $display("FAIL R2/%s bp_out actual=%0b expected=%0b at %0t",
                     exp_tag, bp_out, exp_bp, $time);
        end
        total++;
        if (seg_out !== exp_seg) begin
            bad++;
            $display("FAIL %s seg_out actual=%h expected=%h at %0t",
                     exp_tag, seg_out, exp_seg, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check after the rising edge
    task automatic step(input bit tk);
        osc_tick = tk;
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic run(input int cycles, input int tick_every);
        for (int c = 0; c < cycles; c++) step((c % tick_every) == 0);
    endtask

    initial begin
        logic [N-1:0] pats [4];
        pats[0] = '0;
        pats[1] = '1;
        pats[2] = 38'h15_A5C3_E91B;
        for (int i = 0; i < N; i++) pats[3][i] = ((i % 3) == 1);

        // R1: reset state
        @(negedge clk);
        step(1'b1);
        step(1'b1);
        rst_n = 1'b1;

        // R2..R6, R8: every mode against every pattern, dense ticks
        for (int m = 0; m < 4; m++) begin
            test_sel = m[1:0];
            for (int p = 0; p < 4; p++) begin
                pattern = pats[p];
                run(300, 1);
            end
        end

        // R2: sparse ticks, R8: pattern changed within a backplane period
        test_sel = 2'b00;
        pattern = pats[2];
        run(500, 3);
        pattern = ~pats[2];
        run(400, 3);

        // R7: supply loss in the middle of a period, then restart
        run(150, 1);
        supply_ok = 1'b0;
        run(20, 1);
        supply_ok = 1'b1;
        test_sel = 2'b11;
        run(300, 1);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        run(3, 1);
        rst_n = 1'b1;
        test_sel = 2'b10;
        run(280, 1);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule